// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Unit

This block performs one step of packed decimal arithmetic on a byte that holds two BCD digits. It takes a source byte, a destination byte, an add/subtract select, an incoming extend bit and the current zero flag. It returns the decimal sum (destination + source + extend) or difference (destination − source − extend) as a packed BCD byte, together with five condition flags: extend, carry, zero, negative and overflow.

The arithmetic runs digit by digit. The low digit is formed first and gets a correction of 6 when it leaves the decimal range. The combined byte then gets a correction of 0x60 when the high digit leaves the decimal range. For subtraction, a borrow out of a digit triggers its correction. The zero flag can only be cleared, never set. A longer decimal number can therefore be processed one byte at a time, starting from a zero flag of 1, and the final zero flag shows whether every byte was zero. Digits above 9 are not rejected; they go through the same correction rules. The outputs are registered by default, and a parameter selects a purely combinational variant.

Top module: `bcd_decimal_alu`

## Requirements
- R1: With sub_i=0 and both operands valid BCD, res_o holds the BCD encoding of (dst + src + ext_i) mod 100, and the carry is 1 exactly when that decimal sum is 100 or more.
- R2: With sub_i=1 and both operands valid BCD, res_o holds the BCD encoding of (dst − src − ext_i) mod 100, and the borrow is 1 exactly when that decimal difference is below zero.
- R3: ext_o and carry_o both equal the carry (add) or borrow (subtract) out of the byte.
- R4: zero_o is 0 when res_o is nonzero; otherwise it equals zero_i.
- R5: neg_o equals bit 7 of res_o.
- R6: For add, ovf_o = bit 7 of (NOT(src XOR dst) AND (dst XOR res)).
- R7: For subtract, ovf_o = bit 7 of ((src XOR dst) AND (dst XOR res)).
- R8: With REG_OUT=1, results appear at the outputs one rising clock edge after the inputs are applied, and an active-low reset forces res_o and all flags to 0.
- R9: Digits above 9 are processed without checking, under these rules. Add: the low-nibble sum gets +6 when it exceeds 9, and the whole value gets +0x60 when it exceeds 0x99. Subtract: −6 on a low-nibble borrow and −0x60 on a byte borrow. Examples: 0x0A+0x00 gives 0x10, 0xA0+0x00 gives 0x00 with carry, and 0x0F−0x00 gives 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 8 | Source operand, two packed BCD digits |
| dst_i | input | 8 | Destination operand, two packed BCD digits |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| ext_i | input | 1 | Incoming extend bit (carry or borrow in) |
| zero_i | input | 1 | Current zero flag, carried through the chain |
| res_o | output | 8 | Packed BCD result |
| ext_o | output | 1 | Extend flag out |
| carry_o | output | 1 | Carry/borrow flag out |
| zero_o | output | 1 | Sticky zero flag out |
| neg_o | output | 1 | Negative flag (bit 7 of result) |
| ovf_o | output | 1 | Overflow flag |

## Verification
Every valid digit pair is driven in both directions with both extend values, while the zero-in input alternates. This separates the low-digit correction from the high-digit correction, and it shows whether the extend bit enters at the low digit. Hand-picked rows cover the cases that give a wrong BCD value under a naive threshold: 45+46, which must give 91, and the full-wrap cases 99+99+1 and 00−00−1. Rows with digits above 9 show whether the add correction compares against 9 and 0x99, and whether the subtract correction is triggered by a borrow. Directed steps check the one-edge output latency and the reset state.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int DIGIT_W = 4;
  localparam int BYTE_W  = 2 * DIGIT_W;
  localparam int ACC_W   = BYTE_W + 2;
  localparam logic [ACC_W-1:0] LO_FIX = ACC_W'(6);
  localparam logic [ACC_W-1:0] HI_FIX = ACC_W'(6) << DIGIT_W;
  localparam logic [ACC_W-1:0] LO_MAX = ACC_W'(9);
  localparam logic [ACC_W-1:0] HI_MAX = (ACC_W'(9) << DIGIT_W) | ACC_W'(9);

  typedef struct packed {
    logic x;
    logic c;
    logic z;
    logic n;
    logic v;
  } cc_t;

  function automatic logic [ACC_W-1:0] widen(input logic [DIGIT_W-1:0] d);
    return ACC_W'(d);
  endfunction

  // Low digit, two's complement in ACC_W bits.
  function automatic logic [ACC_W-1:0] low_raw(input logic [DIGIT_W-1:0] d,
                                               input logic [DIGIT_W-1:0] s,
                                               input logic x, input logic sub);
    if (sub) return widen(d) - widen(s) - ACC_W'(x);
    return widen(d) + widen(s) + ACC_W'(x);
  endfunction

  function automatic logic needs_fix(input logic [ACC_W-1:0] raw,
                                     input logic [ACC_W-1:0] limit,
                                     input logic sub);
    if (sub) return raw[ACC_W-1];
    return raw > limit;
  endfunction

  function automatic logic [ACC_W-1:0] apply_fix(input logic [ACC_W-1:0] raw,
                                                 input logic fix, input logic sub,
                                                 input logic [ACC_W-1:0] amount);
    if (!fix) return raw;
    if (sub) return raw - amount;
    return raw + amount;
  endfunction

  function automatic logic [ACC_W-1:0] high_raw(input logic [ACC_W-1:0] lo,
                                                input logic [DIGIT_W-1:0] d,
                                                input logic [DIGIT_W-1:0] s,
                                                input logic sub);
    if (sub) return lo + (widen(d) << DIGIT_W) - (widen(s) << DIGIT_W);
    return lo + (widen(d) << DIGIT_W) + (widen(s) << DIGIT_W);
  endfunction

  function automatic logic carry_of(input logic [ACC_W-1:0] full, input logic sub);
    if (sub) return full[ACC_W-1];
    return |full[ACC_W-1:BYTE_W];
  endfunction

  function automatic logic overflow_of(input logic [BYTE_W-1:0] s,
                                       input logic [BYTE_W-1:0] d,
                                       input logic [BYTE_W-1:0] r,
                                       input logic sub);
    logic [BYTE_W-1:0] t;
    if (sub) t = (s ^ d) & (d ^ r);
    else     t = ~(s ^ d) & (d ^ r);
    return t[BYTE_W-1];
  endfunction
endpackage

// File: rtl/bcd_low_stage.sv
module bcd_low_stage
  import bcd_alu_pkg::*;
(
  input  logic [DIGIT_W-1:0] dst_lo,
  input  logic [DIGIT_W-1:0] src_lo,
  input  logic               ext,
  input  logic               sub,
  output logic [ACC_W-1:0]   lo_sum,
  output logic               lo_fix
);
  logic [ACC_W-1:0] raw;

  always_comb begin
    raw    = low_raw(dst_lo, src_lo, ext, sub);
    lo_fix = needs_fix(raw, LO_MAX, sub);
    lo_sum = apply_fix(raw, lo_fix, sub, LO_FIX);
  end
endmodule

// File: rtl/bcd_high_stage.sv
module bcd_high_stage
  import bcd_alu_pkg::*;
(
  input  logic [ACC_W-1:0]   lo_sum,
  input  logic [DIGIT_W-1:0] dst_hi,
  input  logic [DIGIT_W-1:0] src_hi,
  input  logic               sub,
  output logic [BYTE_W-1:0]  byte_res,
  output logic               hi_fix,
  output logic               carry
);
  logic [ACC_W-1:0] raw;
  logic [ACC_W-1:0] full;

  always_comb begin
    raw      = high_raw(lo_sum, dst_hi, src_hi, sub);
    hi_fix   = needs_fix(raw, HI_MAX, sub);
    full     = apply_fix(raw, hi_fix, sub, HI_FIX);
    carry    = carry_of(full, sub);
    byte_res = full[BYTE_W-1:0];
  end
endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] src,
  input  logic [BYTE_W-1:0] dst,
  input  logic [BYTE_W-1:0] res,
  input  logic              carry,
  input  logic              sub,
  input  logic              zero_in,
  output cc_t               flags
);
  always_comb begin
    flags.x = carry;
    flags.c = carry;
    flags.z = zero_in & (res == '0);
    flags.n = res[BYTE_W-1];
    flags.v = overflow_of(src, dst, res, sub);
  end
endmodule

// File: rtl/bcd_decimal_alu.sv
module bcd_decimal_alu
  import bcd_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] src_i,
  input  logic [BYTE_W-1:0] dst_i,
  input  logic              sub_i,
  input  logic              ext_i,
  input  logic              zero_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              ext_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              ovf_o
);
  logic [ACC_W-1:0]  lo_sum;
  logic              low_fix;
  logic              high_fix;
  logic              carry_out;
  logic [BYTE_W-1:0] nxt_res;
  cc_t               nxt_flags;
  cc_t               cc_out;

  bcd_low_stage u_low (
    .dst_lo (dst_i[DIGIT_W-1:0]),
    .src_lo (src_i[DIGIT_W-1:0]),
    .ext    (ext_i),
    .sub    (sub_i),
    .lo_sum (lo_sum),
    .lo_fix (low_fix)
  );

  bcd_high_stage u_high (
    .lo_sum   (lo_sum),
    .dst_hi   (dst_i[BYTE_W-1:DIGIT_W]),
    .src_hi   (src_i[BYTE_W-1:DIGIT_W]),
    .sub      (sub_i),
    .byte_res (nxt_res),
    .hi_fix   (high_fix),
    .carry    (carry_out)
  );

  bcd_flag_gen u_flags (
    .src     (src_i),
    .dst     (dst_i),
    .res     (nxt_res),
    .carry   (carry_out),
    .sub     (sub_i),
    .zero_in (zero_i),
    .flags   (nxt_flags)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [BYTE_W-1:0] res_q;
      cc_t               cc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '0;
          cc_q  <= '0;
        end else begin
          res_q <= nxt_res;
          cc_q  <= nxt_flags;
        end
      end
      assign res_o  = res_q;
      assign cc_out = cc_q;
    end else begin : g_comb
      assign res_o  = nxt_res;
      assign cc_out = nxt_flags;
    end
  endgenerate

  assign ext_o   = cc_out.x;
  assign carry_o = cc_out.c;
  assign zero_o  = cc_out.z;
  assign neg_o   = cc_out.n;
  assign ovf_o   = cc_out.v;
endmodule

// File: rtl/bcd_decimal_alu_chk.sv
module bcd_decimal_alu_chk
  import bcd_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [BYTE_W-1:0] src_i,
  input logic [BYTE_W-1:0] dst_i,
  input logic              sub_i,
  input logic              zero_i,
  input logic [BYTE_W-1:0] nxt_res,
  input logic              carry_out,
  input logic              nxt_z
);
  function automatic logic bcd_ok(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1:DIGIT_W] <= 4'd9) && (b[DIGIT_W-1:0] <= 4'd9);
  endfunction

  logic both_ok;
  assign both_ok = bcd_ok(src_i) && bcd_ok(dst_i);

  assert_add_digits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_i && both_ok) |-> bcd_ok(nxt_res));

  assert_add_no_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_i && both_ok && !carry_out) |-> (nxt_res >= dst_i));

  assert_sub_digits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_i && both_ok) |-> bcd_ok(nxt_res));

  assert_sub_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_i && both_ok && !carry_out) |-> (nxt_res <= dst_i));

  assert_zero_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_i |-> !nxt_z);

  assert_zero_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_res != '0) |-> !nxt_z);
endmodule

bind bcd_decimal_alu bcd_decimal_alu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .dst_i     (dst_i),
  .sub_i     (sub_i),
  .zero_i    (zero_i),
  .nxt_res   (nxt_res),
  .carry_out (carry_out),
  .nxt_z     (nxt_flags.z)
);

// File: tb/bcd_decimal_alu_bench.sv
module bcd_decimal_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_i = 8'h55;
  logic [7:0] dst_i = 8'h55;
  logic       sub_i = 1'b0;
  logic       ext_i = 1'b1;
  logic       zero_i = 1'b1;
  logic [7:0] res_o;
  logic       ext_o, carry_o, zero_o, neg_o, ovf_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bcd_decimal_alu #(.REG_OUT(1'b1)) u_bcd_decimal_alu (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .dst_i(dst_i), .sub_i(sub_i),
    .ext_i(ext_i), .zero_i(zero_i), .res_o(res_o), .ext_o(ext_o),
    .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o)
  );

  // {raw, sub, ext, src, dst, expected result, expected carry}
  localparam int NROWS = 11;
  localparam logic [27:0] ROWS [NROWS] = '{
    {1'b0, 1'b0, 1'b0, 8'h46, 8'h45, 8'h91, 1'b0},
    {1'b0, 1'b0, 1'b1, 8'h99, 8'h99, 8'h99, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    {1'b0, 1'b0, 1'b0, 8'h50, 8'h50, 8'h00, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'h01, 8'h10, 8'h09, 1'b0},
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'h99, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'h01, 8'h00, 8'h99, 1'b1},
    {1'b0, 1'b1, 1'b1, 8'h17, 8'h42, 8'h24, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h0A, 8'h10, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h00, 8'hA0, 8'h00, 1'b1},
    {1'b1, 1'b1, 1'b0, 8'h00, 8'h0F, 8'h0F, 1'b0}
  };

  function automatic int to_dec(input logic [7:0] b);
    return 10 * int'(b[7:4]) + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Apply at a falling edge, then sample at the next falling edge (one rising edge later).
  task automatic run_vec(input bit sub, input bit ext, input bit zin,
                         input logic [7:0] s, input logic [7:0] d,
                         input logic [7:0] exp_res, input bit exp_c,
                         input string req_main);
    logic [7:0] vt;
    bit exp_v;
    @(negedge clk);
    sub_i = sub; ext_i = ext; zero_i = zin; src_i = s; dst_i = d;
    @(negedge clk);
    check(res_o == exp_res && carry_o == exp_c, req_main, "result/carry",
          {res_o, carry_o}, {exp_res, exp_c});
    check(ext_o == exp_c && carry_o == exp_c, "R3", "ext/carry",
          {ext_o, carry_o}, {exp_c, exp_c});
    check(zero_o == (zin && exp_res == 8'h00), "R4", "zero", zero_o,
          zin && exp_res == 8'h00);
    check(neg_o == exp_res[7], "R5", "neg", neg_o, exp_res[7]);
    if (sub) vt = (s ^ d) & (d ^ exp_res);
    else     vt = ~(s ^ d) & (d ^ exp_res);
    exp_v = vt[7];
    check(ovf_o == exp_v, sub ? "R7" : "R6", "ovf", ovf_o, exp_v);
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R8: reset state with nonzero inputs applied
    repeat (3) @(negedge clk);
    check(res_o == 8'h00 && {ext_o, carry_o, zero_o, neg_o, ovf_o} == 5'b0,
          "R8", "reset outputs", {res_o, ext_o, carry_o, zero_o, neg_o, ovf_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table rows: R1/R2 decimal cases, R9 raw-digit cases
    for (int i = 0; i < NROWS; i++) begin
      logic [27:0] r;
      r = ROWS[i];
      run_vec(r[26], r[25], 1'b1, r[24:17], r[16:9], r[8:1], r[0],
              r[27] ? "R9" : (r[26] ? "R2" : "R1"));
    end

    // Exhaustive valid BCD sweep, both directions, both extend values
    for (int op = 0; op < 2; op++) begin
      for (int xe = 0; xe < 2; xe++) begin
        for (int d = 0; d < 100; d++) begin
          for (int s = 0; s < 100; s++) begin
            int val;
            bit c;
            if (op == 0) begin
              val = d + s + xe;
              c = (val >= 100);
              if (c) val -= 100;
            end else begin
              val = d - s - xe;
              c = (val < 0);
              if (c) val += 100;
            end
            run_vec(op[0], xe[0], s[0] ^ d[0], to_bcd(s), to_bcd(d), to_bcd(val), c,
                    op == 0 ? "R1" : "R2");
          end
        end
      end
    end

    // R8: one-edge latency
    @(negedge clk);
    sub_i = 1'b0; ext_i = 1'b0; zero_i = 1'b1; src_i = 8'h34; dst_i = 8'h12;
    @(posedge clk); #1;
    check(res_o == 8'h46, "R8", "after first edge", res_o, 8'h46);
    @(negedge clk);
    src_i = 8'h01; dst_i = 8'h01;
    #1;
    check(res_o == 8'h46, "R8", "held before edge", res_o, 8'h46);
    @(negedge clk);
    check(res_o == 8'h02, "R8", "after second edge", res_o, 8'h02);
    check(to_dec(res_o) == 2, "R1", "decimal value", to_dec(res_o), 2);

    // R8: asynchronous reset mid-run
    @(negedge clk);
    src_i = 8'h99; dst_i = 8'h99; ext_i = 1'b1;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check(res_o == 8'h00 && carry_o == 1'b0 && ext_o == 1'b0, "R8", "async reset",
          {res_o, carry_o, ext_o}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule